// File: doc/BRIEF.md
# Packet Buffer Memory Manager Command Unit

This block carries out the memory-management commands that a host CPU writes into its command register. The commands act on a small pool of packet buffer pages. Each packet owns one page, and the packet number is the page index. A one-bit-per-page bitmap records which pages are in use. The host can:

- allocate a page for a packet about to be transmitted;
- free the page of a named packet, or of the packet at the head of the receive queue;
- push a packet number into the transmit queue;
- flush the transmit queue and the transmit completion queue in one step.

A command does not act while the host is still writing it. It acts on the falling edge of the write strobe, using the value the strobe held. A release takes a fixed number of cycles, and a BUSY flag is set for that whole time. An allocation reports its outcome in two places. The first is a FAILED bit beside the granted packet number. The second is a one-cycle interrupt pulse. The transmit queue is drained by the MAC through a pop port. The completion queue is filled by the MAC and read by the host through a FIFO read port. The receive queue lies outside the block; the block sees only its head entry and pops it.

Top module: `mmu_cmd_unit`

## Requirements
- R1: The command code is bits [7:5] of the written byte, and bits [4:0] are ignored. A command acts in the first clock after `cmd_wr` is seen low having been high, using the byte captured while `cmd_wr` was high. The codes are: 001 allocate, 100 release receive head, 101 release the packet in the packet number register, 110 enqueue, 111 flush the transmit queues. Codes 000, 010 and 011 change nothing.
- R2: On an allocate, FAILED goes to 1 at the strobe's trailing edge. One cycle later FAILED goes to 0, `alloc_pnum` holds the lowest-numbered free page, that page's bit in `pool_used` goes to 1, and `alloc_irq` is 1 for exactly one cycle.
- R3: If an allocate finds every page in use, FAILED stays 1, `pool_used` is unchanged, and `alloc_irq` still pulses for one cycle.
- R4: A release sets BUSY (`cmd_rdata[0]`) at the trailing edge and holds it for exactly REL_LAT cycles. The target page's `pool_used` bit clears in the same edge where BUSY falls.
- R5: A release of the receive head with `rx_head_valid` high pulses `rx_pop` for one cycle at the trailing edge, while BUSY is high. When the release finishes, it frees page `rx_head_pnum`.
- R6: While BUSY is 1, a new release command is ignored, and a write to the packet number register is ignored; `pnr_rdata` keeps its old value.
- R7: A release of a packet whose page is not in use leaves `pool_used` unchanged.
- R8: An enqueue pushes the packet number register's value into the transmit queue. The MAC pops entries in first-in first-out order through `tx_pnum`/`tx_pop`. An enqueue into a full queue (QDEPTH entries) is dropped.
- R9: A flush empties both the transmit queue and the completion queue, and leaves `pool_used` unchanged.
- R10: Packet numbers pushed by the MAC into the completion queue are read by the host in first-in first-out order through `done_pnum`/`done_rd`.
- R11: After reset, no page is in use, BUSY and FAILED are 0, both queues are empty, and `alloc_irq` and `rx_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Command register readback, bit 0 = BUSY |
| pnr_wr | input | 1 | Packet number register write |
| pnr_wdata | input | PW | Packet number to store |
| pnr_rdata | output | PW | Packet number register readback |
| alloc_failed | output | 1 | Allocation FAILED bit |
| alloc_pnum | output | PW | Packet number granted by the last allocation |
| alloc_irq | output | 1 | One-cycle allocation-complete pulse |
| pool_used | output | NPAGES | Page-in-use bitmap |
| tx_pop | input | 1 | MAC pops the transmit queue head |
| tx_pnum | output | PW | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| done_push | input | 1 | MAC pushes a completed packet number |
| done_pnum_in | input | PW | Completed packet number |
| done_rd | input | 1 | Host reads (pops) the completion queue |
| done_pnum | output | PW | Completion queue head |
| done_empty | output | 1 | Completion queue empty |
| rx_head_valid | input | 1 | Receive queue holds an entry |
| rx_head_pnum | input | PW | Packet number at the receive queue head |
| rx_pop | output | 1 | Pop request to the receive queue |

## Verification
Every command lands at trailing edge T, the first clock with the strobe low. FAILED, BUSY, `rx_pop` and queue pushes appear just after T. The allocation result, the bitmap update and the interrupt appear one clock later. A release clears BUSY and the page bit REL_LAT clocks after T. The bench drives inputs on falling edges and counts falling edges from the return of the command task. Each check is sampled in exactly the half-cycle where its result is due, and BUSY is checked high in every intermediate half-cycle.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam logic [2:0] OP_ALLOC  = 3'b001;
  localparam logic [2:0] OP_REL_RX = 3'b100;
  localparam logic [2:0] OP_REL_PN = 3'b101;
  localparam logic [2:0] OP_ENQ    = 3'b110;
  localparam logic [2:0] OP_TXRST  = 3'b111;

  // Opcode field of the command byte; the low five bits carry no meaning.
  function automatic logic [2:0] op_of(input logic [7:0] b);
    return b[7:5];
  endfunction

  function automatic logic is_release(input logic [2:0] op);
    return (op == OP_REL_RX) || (op == OP_REL_PN);
  endfunction
endpackage

// File: rtl/mmu_fifo.sv
module mmu_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mmu_page_pool.sv
module mmu_page_pool #(
  parameter int NPAGES = 8,
  parameter int PW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [PW-1:0]     set_idx,
  input  logic              clr_en,
  input  logic [PW-1:0]     clr_idx,
  output logic [NPAGES-1:0] used,
  output logic              free_avail,
  output logic [PW-1:0]     free_idx
);
  // Lowest-numbered free page, with a found flag in the top bit.
  function automatic logic [PW:0] pick_free(input logic [NPAGES-1:0] u);
    logic [PW:0] r;
    r = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (!u[i]) r = {1'b1, PW'(i)};
    return r;
  endfunction

  logic [PW:0] pick;
  assign pick       = pick_free(used);
  assign free_avail = pick[PW];
  assign free_idx   = pick[PW-1:0];

  for (genvar g = 0; g < NPAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)
        used[g] <= 1'b0;
      else if (set_en && set_idx == PW'(g))
        used[g] <= 1'b1;
      else if (clr_en && clr_idx == PW'(g))
        used[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/mmu_cmd_unit.sv
module mmu_cmd_unit
  import mmu_pkg::*;
#(
  parameter int NPAGES  = 8,
  parameter int PW      = $clog2(NPAGES),
  parameter int QDEPTH  = 4,
  parameter int REL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_wdata,
  output logic [7:0]        cmd_rdata,
  input  logic              pnr_wr,
  input  logic [PW-1:0]     pnr_wdata,
  output logic [PW-1:0]     pnr_rdata,
  output logic              alloc_failed,
  output logic [PW-1:0]     alloc_pnum,
  output logic              alloc_irq,
  output logic [NPAGES-1:0] pool_used,
  input  logic              tx_pop,
  output logic [PW-1:0]     tx_pnum,
  output logic              tx_empty,
  input  logic              done_push,
  input  logic [PW-1:0]     done_pnum_in,
  input  logic              done_rd,
  output logic [PW-1:0]     done_pnum,
  output logic              done_empty,
  input  logic              rx_head_valid,
  input  logic [PW-1:0]     rx_head_pnum,
  output logic              rx_pop
);
  localparam int CW = $clog2(REL_LAT + 1);

  // Strobe capture and trailing-edge decode
  logic       wr_q;
  logic [7:0] cmd_q;
  logic [2:0] op;
  logic       trail_evt, rel_start, rel_done, alloc_start, alloc_done;
  logic       enq_evt, flush_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      cmd_q <= '0;
    end else begin
      wr_q <= cmd_wr;
      if (cmd_wr) cmd_q <= cmd_wdata;
    end
  end

  assign op        = op_of(cmd_q);
  assign trail_evt = wr_q && !cmd_wr;

  // Release engine
  logic          busy;
  logic [CW-1:0] rel_cnt;
  logic [PW-1:0] rel_pn;
  logic          rel_ok;
  logic [PW-1:0] pnr_q;

  assign rel_start = trail_evt && is_release(op) && !busy;
  assign rel_done  = busy && (rel_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rel_cnt <= '0;
      rel_pn  <= '0;
      rel_ok  <= 1'b0;
      rx_pop  <= 1'b0;
    end else begin
      rx_pop <= rel_start && (op == OP_REL_RX) && rx_head_valid;
      if (rel_start) begin
        busy    <= 1'b1;
        rel_cnt <= CW'(REL_LAT - 1);
        rel_pn  <= (op == OP_REL_RX) ? rx_head_pnum : pnr_q;
        rel_ok  <= (op == OP_REL_PN) || rx_head_valid;
      end else if (rel_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        rel_cnt <= rel_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                pnr_q <= '0;
    else if (pnr_wr && !busy)  pnr_q <= pnr_wdata;
  end

  // Allocation engine
  logic          alloc_pend;
  logic          free_avail;
  logic [PW-1:0] free_idx;

  assign alloc_start = trail_evt && (op == OP_ALLOC) && !alloc_pend;
  assign alloc_done  = alloc_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_pend   <= 1'b0;
      alloc_failed <= 1'b0;
      alloc_pnum   <= '0;
      alloc_irq    <= 1'b0;
    end else begin
      alloc_pend <= alloc_start;
      alloc_irq  <= alloc_done;
      if (alloc_start) begin
        alloc_failed <= 1'b1;
      end else if (alloc_done) begin
        alloc_failed <= !free_avail;
        if (free_avail) alloc_pnum <= free_idx;
      end
    end
  end

  mmu_page_pool #(.NPAGES(NPAGES), .PW(PW)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (alloc_done && free_avail),
    .set_idx    (free_idx),
    .clr_en     (rel_done && rel_ok),
    .clr_idx    (rel_pn),
    .used       (pool_used),
    .free_avail (free_avail),
    .free_idx   (free_idx)
  );

  // Transmit and completion queues
  logic tx_full_w, done_full_w;

  assign enq_evt   = trail_evt && (op == OP_ENQ);
  assign flush_evt = trail_evt && (op == OP_TXRST);

  mmu_fifo #(.W(PW), .DEPTH(QDEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_evt),
    .push      (enq_evt),
    .push_data (pnr_q),
    .pop       (tx_pop),
    .head      (tx_pnum),
    .empty     (tx_empty),
    .full      (tx_full_w)
  );

  mmu_fifo #(.W(PW), .DEPTH(QDEPTH)) u_doneq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_evt),
    .push      (done_push),
    .push_data (done_pnum_in),
    .pop       (done_rd),
    .head      (done_pnum),
    .empty     (done_empty),
    .full      (done_full_w)
  );

  assign cmd_rdata = {7'b0, busy};
  assign pnr_rdata = pnr_q;
endmodule

// File: rtl/mmu_cmd_chk.sv
module mmu_cmd_chk #(
  parameter int NPAGES  = 8,
  parameter int PW      = 3,
  parameter int REL_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rel_start,
  input logic              rel_done,
  input logic              alloc_done,
  input logic              flush_evt,
  input logic [PW-1:0]     pnr_q,
  input logic              alloc_irq,
  input logic              alloc_failed,
  input logic [PW-1:0]     alloc_pnum,
  input logic [NPAGES-1:0] pool_used,
  input logic              tx_empty,
  input logic              done_empty,
  input logic              rx_pop
);
  logic [15:0] busy_cycles;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cycles <= '0;
    else                 busy_cycles <= busy_cycles + 1'b1;
  end

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rel_start));
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cycles < 16'(REL_LAT)));
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !busy);
  p_pnr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pnr_q));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (tx_empty && done_empty));
  p_flush_pool_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_evt && !rel_done && !alloc_done) |=> $stable(pool_used));
  p_alloc_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_irq && !alloc_failed) |-> pool_used[alloc_pnum]);
  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq |=> !alloc_irq);
  p_rx_pop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> busy);
endmodule

bind mmu_cmd_unit mmu_cmd_chk #(.NPAGES(NPAGES), .PW(PW), .REL_LAT(REL_LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rel_start    (rel_start),
  .rel_done     (rel_done),
  .alloc_done   (alloc_done),
  .flush_evt    (flush_evt),
  .pnr_q        (pnr_q),
  .alloc_irq    (alloc_irq),
  .alloc_failed (alloc_failed),
  .alloc_pnum   (alloc_pnum),
  .pool_used    (pool_used),
  .tx_empty     (tx_empty),
  .done_empty   (done_empty),
  .rx_pop       (rx_pop)
);

// File: tb/tb_mmu_cmd_unit.sv
`timescale 1ns/1ps
module tb_mmu_cmd_unit;
  localparam int NP = 8, PW = 3, QD = 4, RL = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, pnr_wr = 0, tx_pop = 0, done_push = 0, done_rd = 0, rx_head_valid = 0;
  logic [7:0] cmd_wdata = 0, cmd_rdata;
  logic [PW-1:0] pnr_wdata = 0, pnr_rdata, alloc_pnum, tx_pnum, done_pnum_in = 0, done_pnum;
  logic [PW-1:0] rx_head_pnum = 0;
  logic alloc_failed, alloc_irq, tx_empty, done_empty, rx_pop;
  logic [NP-1:0] pool_used;

  int errors = 0, checks = 0;
  logic [NP-1:0] model = '0;

  always #2.5 clk = ~clk;

  mmu_cmd_unit #(.NPAGES(NP), .QDEPTH(QD), .REL_LAT(RL)) dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest_free(input logic [NP-1:0] m);
    for (int i = 0; i < NP; i++) if (!m[i]) return i;
    return -1;
  endfunction

  task automatic do_cmd(input logic [2:0] code, input int hold);
    cmd_wr = 1; cmd_wdata = {code, 5'($urandom)};
    repeat (hold) @(negedge clk);
    cmd_wr = 0;
    @(negedge clk);
  endtask

  task automatic set_pnr(input int v);
    pnr_wr = 1; pnr_wdata = PW'(v);
    @(negedge clk);
    pnr_wr = 0;
  endtask

  task automatic alloc_check(input string tag);
    int ff;
    ff = lowest_free(model);
    do_cmd(3'b001, 1 + ($urandom % 3));
    chk(alloc_failed, 1, {tag, " FAILED at trailing edge"});
    @(negedge clk);
    chk(alloc_irq, 1, {tag, " irq"});
    if (ff < 0) begin
      chk(alloc_failed, 1, {tag, " R3 full"});
    end else begin
      model[ff] = 1'b1;
      chk(alloc_failed, 0, {tag, " failed clear"});
      chk(alloc_pnum, ff, {tag, " pnum"});
    end
    chk(pool_used, model, {tag, " pool"});
    @(negedge clk);
    chk(alloc_irq, 0, {tag, " irq one cycle"});
  endtask

  task automatic release_check(input int pn, input string tag);
    set_pnr(pn);
    do_cmd(3'b101, 1);
    for (int k = 0; k < RL; k++) begin
      chk(cmd_rdata[0], 1, {tag, " busy"});
      chk(pool_used, model, {tag, " pool before done"});
      @(negedge clk);
    end
    model[pn] = 1'b0;
    chk(cmd_rdata[0], 0, {tag, " busy low"});
    chk(pool_used, model, {tag, " pool after"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(pool_used, 0, "R11 pool");
    chk(cmd_rdata, 0, "R11 busy");
    chk(alloc_failed, 0, "R11 failed");
    chk(tx_empty, 1, "R11 tx empty");
    chk(done_empty, 1, "R11 done empty");
    chk(alloc_irq, 0, "R11 irq");
    chk(rx_pop, 0, "R11 rx_pop");

    // R2 fill the pool, R3 allocate when full
    for (int i = 0; i < NP; i++) alloc_check("R2");
    alloc_check("R3");

    // R4 release a named packet
    release_check(3, "R4");

    // R6 release and pnr write while busy are ignored
    set_pnr(5);
    do_cmd(3'b101, 1);
    set_pnr(2);
    chk(pnr_rdata, 5, "R6 pnr held");
    do_cmd(3'b101, 1);
    for (int k = 0; k < 20 && cmd_rdata[0]; k++) @(negedge clk);
    model[5] = 1'b0;
    chk(pool_used, model, "R6 first release");
    repeat (RL) @(negedge clk);
    chk(cmd_rdata[0], 0, "R6 second release ignored");
    chk(pool_used, model, "R6 pool");

    // R7 release of an unused page
    release_check(5, "R7");

    // R5 release receive head
    rx_head_valid = 1; rx_head_pnum = 0;
    do_cmd(3'b100, 2);
    chk(rx_pop, 1, "R5 rx_pop");
    chk(cmd_rdata[0], 1, "R5 busy");
    @(negedge clk);
    chk(rx_pop, 0, "R5 rx_pop pulse");
    repeat (RL - 1) @(negedge clk);
    model[0] = 1'b0;
    chk(pool_used, model, "R5 page freed");
    rx_head_valid = 0;

    // R1 unused opcodes
    do_cmd(3'b010, 1); do_cmd(3'b011, 2); do_cmd(3'b000, 1);
    @(negedge clk);
    chk(pool_used, model, "R1 pool");
    chk(cmd_rdata[0], 0, "R1 busy");
    chk(tx_empty, 1, "R1 tx");
    chk(alloc_irq, 0, "R1 irq");

    // R8 enqueue order and overflow drop
    begin
      int vals[5] = '{1, 2, 6, 7, 4};
      for (int i = 0; i < 5; i++) begin set_pnr(vals[i]); do_cmd(3'b110, 1); end
      for (int i = 0; i < QD; i++) begin
        chk(tx_empty, 0, "R8 not empty");
        chk(tx_pnum, vals[i], "R8 order");
        tx_pop = 1; @(negedge clk); tx_pop = 0;
      end
      chk(tx_empty, 1, "R8 overflow dropped");
    end

    // R10 completion queue
    for (int i = 0; i < 3; i++) begin
      done_push = 1; done_pnum_in = PW'(7 - i); @(negedge clk);
    end
    done_push = 0;
    for (int i = 0; i < 3; i++) begin
      chk(done_pnum, 7 - i, "R10 order");
      done_rd = 1; @(negedge clk); done_rd = 0;
    end
    chk(done_empty, 1, "R10 drained");

    // R9 flush both queues, pool untouched
    set_pnr(4); do_cmd(3'b110, 1); do_cmd(3'b110, 1);
    done_push = 1; done_pnum_in = 3; @(negedge clk); done_push = 0;
    chk(tx_empty, 0, "R9 tx loaded");
    do_cmd(3'b111, 1);
    chk(tx_empty, 1, "R9 tx flushed");
    chk(done_empty, 1, "R9 done flushed");
    chk(pool_used, model, "R9 pool");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      case ($urandom % 3)
        0: alloc_check("R2 rnd");
        1: begin
          int pn;
          pn = $urandom % NP;
          release_check(pn, "R4 rnd");
        end
        default: begin
          int pn;
          pn = $urandom % NP;
          set_pnr(pn);
          do_cmd(3'b110, 1 + ($urandom % 2));
          chk(tx_pnum, pn, "R8 rnd");
          tx_pop = 1; @(negedge clk); tx_pop = 0;
          chk(tx_empty, 1, "R8 rnd empty");
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule